// File: doc/BRIEF.md
# Self-Synchronizing and Frame-Synchronized Bit Scrambler Pair

The block holds a transmit scrambler lane and a receive descrambler lane for one serial bit stream. Each lane accepts at most one bit per clock, qualified by its own valid strobe. The processed bit appears on a registered output one cycle later, together with an output valid.

A mode input selects one of two schemes, both built on the recursion 1 + D + D^3. In self-synchronizing mode the transmit side feeds its own output back through a three-stage history. The receive side runs the received bits through a matching feed-forward history. The receiver therefore locks onto the stream without a shared start point. In frame-synchronized mode both sides add a seven-bit pseudo-noise sequence to the data. The sequence comes from a three-stage maximal-length LFSR that an init pulse presets to all ones on both lanes at once.

Top module: `scr_link`

## Requirements
- R1: While rst_ni is low, every history stage, PN stage and output register clears to zero, so tx_bit_o, rx_bit_o, tx_vld_o and rx_vld_o read 0 after reset.
- R2: With mode_i = 0, each accepted transmit bit S produces T = S xor T1 xor T3, where T1 and T3 are the lane's own outputs one and three accepted bits earlier (zero after reset).
- R3: With mode_i = 0, each accepted receive bit R produces R xor R1 xor R3, where R1 and R3 are the received bits one and three accepted bits earlier.
- R4: A bit presented with valid high and init_i low appears on the output on the following clock edge, and the matching output valid is high for exactly that cycle. When valid is low, no state moves and the output bit holds its value.
- R5: With mode_i = 1, the output is the input xor a PN bit. After an init pulse, the PN bits for successive accepted bits are 0,1,0,0,1,1,1, repeating with period 7. The PN register advances on every accepted bit in either mode.
- R6: init_i presets the PN register of both lanes to all ones. A bit presented in the init cycle is dropped: no output valid follows, and the output bit holds its value.
- R7: In frame mode after reset and without any init, the PN register stays at zero, so data passes through unchanged.
- R8: With the receive lane fed the transmit output and both lanes started together, the descrambled bit equals the original bit in either mode.
- R9: A self-synchronizing receive lane that starts with a history different from the transmitter's delivers correct data from the fourth chained bit on.
- R10: In self-synchronizing mode, one flipped received bit corrupts exactly three descrambled bits: the bit itself and the bits one and three positions later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Preset of the PN register on both lanes |
| mode_i | input | 1 | 0 = self-synchronizing, 1 = frame-synchronized |
| tx_valid_i | input | 1 | Transmit bit strobe |
| tx_bit_i | input | 1 | Plain data bit |
| tx_vld_o | output | 1 | Scrambled bit valid |
| tx_bit_o | output | 1 | Scrambled bit |
| rx_valid_i | input | 1 | Receive bit strobe |
| rx_bit_i | input | 1 | Received scrambled bit |
| rx_vld_o | output | 1 | Descrambled bit valid |
| rx_bit_o | output | 1 | Descrambled bit |

## Verification
A wrong stage in a transmit history shows up at tx_bit_o within three accepted bits. It then keeps disturbing the stream, because the error is fed back into the recursion. A wrong receive history shows up at rx_bit_o within three accepted bits and clears itself after three more. For that reason the bench compares every output on every clock against an independent model, rather than only looking at the end result. A PN register preset to the wrong value or stepped at the wrong time breaks the fixed seven-bit pattern on the first bit after init. The bench checks that pattern with all-zero data.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    MODE_SELF  = 1'b0,
    MODE_FRAME = 1'b1
  } scr_mode_e;

  localparam int unsigned SCR_DEPTH = 3;
  // bit k selects the stage delayed by k+1: D^1 and D^3
  localparam logic [SCR_DEPTH-1:0] SCR_TAPS = 3'b101;
endpackage

// File: rtl/scr_pn_gen.sv
module scr_pn_gen #(
  parameter int unsigned DEPTH = 3,
  parameter logic [DEPTH-1:0] TAPS = 3'b101
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic preset_i,
  input  logic adv_i,
  output logic key_o
);
  logic [DEPTH-1:0] state_q;

  assign key_o = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= '0;
    else if (preset_i) state_q <= '1;
    else if (adv_i)    state_q <= {state_q[DEPTH-2:0], key_o};
  end
endmodule

// File: rtl/scr_hist.sv
module scr_hist #(
  parameter int unsigned DEPTH = 3,
  parameter logic [DEPTH-1:0] TAPS = 3'b101
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic bit_i,
  output logic fb_o
);
  logic [DEPTH-1:0] hist_q;

  assign fb_o = ^(hist_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[DEPTH-2:0], bit_i};
  end
endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
#(
  parameter int unsigned DEPTH = SCR_DEPTH,
  parameter logic [DEPTH-1:0] TAPS = SCR_TAPS,
  parameter bit IS_TX = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic mode_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic valid_o,
  output logic bit_o
);
  logic accept, pn_key, hist_fb, key, res, hist_in;
  logic vld_q, bit_q;

  assign accept = valid_i & ~init_i;

  scr_pn_gen #(.DEPTH(DEPTH), .TAPS(TAPS)) u_pn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .preset_i(init_i),
    .adv_i   (accept),
    .key_o   (pn_key)
  );

  // feedback on own output (tx) or feed-forward on received bits (rx)
  generate
    if (IS_TX) begin : g_fb
      assign hist_in = res;
    end else begin : g_ff
      assign hist_in = bit_i;
    end
  endgenerate

  scr_hist #(.DEPTH(DEPTH), .TAPS(TAPS)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(accept),
    .bit_i  (hist_in),
    .fb_o   (hist_fb)
  );

  assign key = (scr_mode_e'(mode_i) == MODE_FRAME) ? pn_key : hist_fb;
  assign res = bit_i ^ key;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= accept;
      if (accept) bit_q <= res;
    end
  end

  assign valid_o = vld_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/scr_link.sv
module scr_link
  import scr_pkg::*;
#(
  parameter int unsigned DEPTH = SCR_DEPTH,
  parameter logic [DEPTH-1:0] TAPS = SCR_TAPS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic mode_i,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  output logic tx_vld_o,
  output logic tx_bit_o,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  output logic rx_vld_o,
  output logic rx_bit_o
);
  scr_lane #(.DEPTH(DEPTH), .TAPS(TAPS), .IS_TX(1'b1)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .mode_i (mode_i),
    .valid_i(tx_valid_i),
    .bit_i  (tx_bit_i),
    .valid_o(tx_vld_o),
    .bit_o  (tx_bit_o)
  );

  scr_lane #(.DEPTH(DEPTH), .TAPS(TAPS), .IS_TX(1'b0)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .mode_i (mode_i),
    .valid_i(rx_valid_i),
    .bit_i  (rx_bit_i),
    .valid_o(rx_vld_o),
    .bit_o  (rx_bit_o)
  );
endmodule

// File: rtl/scr_link_chk.sv
module scr_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic init_i,
  input logic tx_valid_i,
  input logic tx_vld_o,
  input logic tx_bit_o,
  input logic rx_valid_i,
  input logic rx_vld_o,
  input logic rx_bit_o
);
  assert_tx_vld_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(tx_valid_i && !init_i));

  assert_rx_vld_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> $past(rx_valid_i && !init_i));

  assert_tx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> $stable(tx_bit_o) && !tx_vld_o);

  assert_rx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(rx_bit_o) && !rx_vld_o);

  assert_init_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !tx_vld_o && !rx_vld_o && $stable(tx_bit_o) && $stable(rx_bit_o));
endmodule

bind scr_link scr_link_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .init_i    (init_i),
  .tx_valid_i(tx_valid_i),
  .tx_vld_o  (tx_vld_o),
  .tx_bit_o  (tx_bit_o),
  .rx_valid_i(rx_valid_i),
  .rx_vld_o  (rx_vld_o),
  .rx_bit_o  (rx_bit_o)
);

// File: tb/scr_link_tb_top.sv
`timescale 1ns/1ps
module scr_link_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, mode = 1'b0;
  logic tv = 1'b0, tb = 1'b0, rv = 1'b0, rb = 1'b0;
  logic tx_vld, tx_bit, rx_vld, rx_bit;

  int n_run = 0, n_fail = 0, cyc = 0;

  // PN bits after preset, index 0 in LSB: 0,1,0,0,1,1,1
  localparam bit [6:0] PN_SEQ = 7'b1110010;

  // reference model state
  bit th[3], rh[3];
  int tpn, rpn;
  bit tlive, rlive;
  bit e_tv, e_tb, e_rv, e_rb;

  always #2.5 clk = ~clk;

  scr_link dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .mode_i(mode),
    .tx_valid_i(tv), .tx_bit_i(tb), .tx_vld_o(tx_vld), .tx_bit_o(tx_bit),
    .rx_valid_i(rv), .rx_bit_i(rb), .rx_vld_o(rx_vld), .rx_bit_o(rx_bit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      finish_run();
    end
  end

  function automatic bit tx_key(bit md);
    if (md) return tlive ? PN_SEQ[tpn] : 1'b0;
    return th[0] ^ th[2];
  endfunction

  function automatic bit rx_key(bit md);
    if (md) return rlive ? PN_SEQ[rpn] : 1'b0;
    return rh[0] ^ rh[2];
  endfunction

  task automatic model_reset();
    th = '{0,0,0}; rh = '{0,0,0};
    tpn = 0; rpn = 0; tlive = 0; rlive = 0;
    e_tv = 0; e_tb = 0; e_rv = 0; e_rb = 0;
  endtask

  // one clock: drive at negedge, compare at the next negedge
  task automatic step(input bit v_t, b_t, v_r, b_r, ini, md, input string tag);
    tv = v_t; tb = b_t; rv = v_r; rb = b_r; init = ini; mode = md;
    if (ini) begin
      e_tv = 0; e_rv = 0;
      tpn = 0; rpn = 0; tlive = 1; rlive = 1;
    end else begin
      e_tv = v_t;
      if (v_t) begin
        e_tb = b_t ^ tx_key(md);
        th[2] = th[1]; th[1] = th[0]; th[0] = e_tb;
        tpn = (tpn + 1) % 7;
      end
      e_rv = v_r;
      if (v_r) begin
        e_rb = b_r ^ rx_key(md);
        rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = b_r;
        rpn = (rpn + 1) % 7;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tx_vld == e_tv, {tag, " tx_vld"}, tx_vld, e_tv);
    check(tx_bit == e_tb, {tag, " tx_bit"}, tx_bit, e_tb);
    check(rx_vld == e_rv, {tag, " rx_vld"}, rx_vld, e_rv);
    check(rx_bit == e_rb, {tag, " rx_bit"}, rx_bit, e_rb);
  endtask

  // chained bit: receive lane gets the scrambled value, optionally flipped
  task automatic link(input bit b, input bit md, input bit flip, input string tag);
    bit scr;
    scr = b ^ tx_key(md);
    step(1'b1, b, 1'b1, scr ^ flip, 1'b0, md, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tv = 0; rv = 0; init = 0; tb = 0; rb = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    bit b;
    bit [6:0] err;
    do_reset();
    // R1: cleared outputs
    check(tx_vld == 0 && rx_vld == 0, "R1 valids", {tx_vld, rx_vld}, 0);
    check(tx_bit == 0 && rx_bit == 0, "R1 bits", {tx_bit, rx_bit}, 0);

    // R2 R3 R8 R4: self mode chained, idle gaps hold outputs
    for (int i = 0; i < 40; i++) begin
      b = ($urandom % 2) == 1;
      link(b, 1'b0, 1'b0, "R2_R3");
      check(rx_bit == b, "R8 self round trip", rx_bit, b);
      if (i % 5 == 4) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 idle");
    end

    // R10: one flipped received bit -> errors at offsets 0,1,3
    for (int i = 0; i < 7; i++) begin
      b = ($urandom % 2) == 1;
      link(b, 1'b0, i == 0, "R10");
      err[i] = (rx_bit != b);
    end
    check(err == 7'b0001011, "R10 error pattern", err, 7'b0001011);

    // R9: desynchronize receive history, then recover after 3 bits
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 skew");
    for (int i = 0; i < 12; i++) begin
      b = ($urandom % 2) == 1;
      link(b, 1'b0, 1'b0, "R9");
      if (i >= 3) check(rx_bit == b, "R9 recovered", rx_bit, b);
    end

    // R6: init with valid high drops the bit
    step(1'b1, ~e_tb, 1'b1, ~e_rb, 1'b1, 1'b1, "R6 init");
    // R5: zero data exposes the PN sequence
    for (int i = 0; i < 14; i++) begin
      link(1'b0, 1'b1, 1'b0, "R5");
      check(tx_bit == PN_SEQ[i % 7], "R5 pn bit", tx_bit, PN_SEQ[i % 7]);
      check(rx_bit == 1'b0, "R8 frame zero", rx_bit, 0);
    end
    for (int i = 0; i < 30; i++) begin
      b = ($urandom % 2) == 1;
      link(b, 1'b1, 1'b0, "R5");
      check(rx_bit == b, "R8 frame round trip", rx_bit, b);
      if (i % 7 == 3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 frame idle");
    end

    // R7: frame mode without init passes data unchanged
    do_reset();
    for (int i = 0; i < 10; i++) begin
      b = ($urandom % 2) == 1;
      link(b, 1'b1, 1'b0, "R7");
      check(tx_bit == b, "R7 passthrough", tx_bit, b);
    end
    finish_run();
  end
endmodule